// File: doc/BRIEF.md
# UART Receive Idle and Character Time-Out Detector

This block sits beside a UART receiver. It watches the serial receive line and the occupancy of the receive FIFO, and it raises two flags. `line_idle` reports that the line has been quiet for long enough to allow sleep entry. `rx_timeout_irq` requests service when characters sit in the FIFO and no new traffic has arrived for a while. Both detectors measure time in bit periods. A bit period is built from a 16x oversampling tick, and the line is sampled once per bit, in the middle of the bit.

The time window is four character times. A character time is the number of bits in one frame, and the frame shape is set by three configuration inputs: data length, parity enable and stop-bit count. The two detectors share the bit timing but obey different rules. The idle detector restarts only on line activity. The time-out detector runs only while the FIFO is non-empty, and it restarts on line activity or on a holding-register read.

Idle state machine: `IDL_WATCH` (counting quiet bits), `IDL_QUIET` (flag raised). It moves from WATCH to QUIET when the window is reached, and from QUIET to WATCH on a falling edge. Time-out state machine: `TO_EMPTY` (FIFO empty, counter held clear), `TO_TIMING` (counting), `TO_EXPIRED` (request raised). Its transitions are:
- EMPTY to TIMING when the FIFO becomes non-empty.
- TIMING to EXPIRED when the window is reached.
- TIMING to EMPTY, and EXPIRED to EMPTY, when the FIFO empties.
- EXPIRED to TIMING on a holding-register read.

Top module: `uart_rx_timeout`

## Requirements
- R1: During and right after reset, `line_idle` and `rx_timeout_irq` are both 0.
- R2: A character time is 1 + (5 + `data_bits_sel`) + `parity_en` + (1 + `two_stop`) bits, where `data_bits_sel` 0..3 selects 5..8 data bits. The window for both detectors is 4 character times (28 to 48 bits).
- R3: `rx_in` passes through a two-flop synchronizer. Activity is a high-to-low transition of the synchronized line.
- R4: The line is sampled on the 8th of every 16 `baud_tick16` pulses. The tick phase restarts at each activity, so samples fall mid-bit.
- R5: `line_idle` rises once a full window of consecutive high mid-bit samples has been taken since the last activity or reset.
- R6: Activity drops `line_idle` within three clocks and restarts the idle count.
- R7: `fifo_not_empty`, `rhr_read` and the time-out state have no effect on `line_idle`.
- R8: While `fifo_not_empty` is 0 the time-out count is held clear and `rx_timeout_irq` stays 0.
- R9: With the FIFO non-empty and no activity or read, `rx_timeout_irq` rises after one full window of bit periods.
- R10: Activity or an `rhr_read` pulse restarts the time-out count from zero.
- R11: Once raised, `rx_timeout_irq` stays 1 until `rhr_read` or the FIFO empties, and it falls the next cycle. Line activity does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| rx_in | input | 1 | Asynchronous serial receive line |
| data_bits_sel | input | 2 | Data length: 0..3 gives 5..8 bits |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| fifo_not_empty | input | 1 | Receive FIFO holds at least one entry |
| rhr_read | input | 1 | One-cycle strobe: holding register was read |
| line_idle | output | 1 | Receive line quiet for four character times |
| rx_timeout_irq | output | 1 | Character time-out request |

## Verification
The hardest cases to reach are restarts that arrive part-way through a window. One is an `rhr_read` or a falling edge well into the time-out count; the other is line activity while the request is already raised. Both must be placed late enough that a missed restart would change the outcome.

The stimulus handles this in two ways. Directed sequences place each restart at about half a window and then check the level just before and just after the fresh window would end. Random frame shapes, with random restart points, repeat the same bracketing, and the expected windows are computed from the frame-length formula.

// File: rtl/uart_rto_pkg.sv
package uart_rto_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int CHARS_IN_WINDOW = 4;
    localparam int MIN_DATA_BITS = 5;
    localparam int MAX_FRAME_BITS = 1 + MIN_DATA_BITS + 3 + 1 + 2;
    localparam int WIN_W = $clog2(CHARS_IN_WINDOW * MAX_FRAME_BITS + 1);

    typedef enum logic [0:0] {
        IDL_WATCH,
        IDL_QUIET
    } idle_st_t;

    typedef enum logic [1:0] {
        TO_EMPTY,
        TO_TIMING,
        TO_EXPIRED
    } to_st_t;

    function automatic logic [WIN_W-1:0] window_bits(
        input logic [1:0] dsel,
        input logic       par,
        input logic       stop2
    );
        logic [WIN_W-1:0] frame;
        frame = WIN_W'(1 + MIN_DATA_BITS + 1) + WIN_W'(dsel)
              + WIN_W'(par) + WIN_W'(stop2);
        return WIN_W'(CHARS_IN_WINDOW) * frame;
    endfunction

endpackage

// File: rtl/rto_rx_sync.sv
module rto_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_level,
    output logic rx_fall
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= rx_async;
                end else begin
                    chain[i] <= chain[(i > 0) ? i-1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b1;
        else        level_d <= chain[STAGES-1];
    end

    assign rx_level = chain[STAGES-1];
    assign rx_fall  = level_d & ~chain[STAGES-1];

    // R3: a detected edge follows a high level one cycle earlier
    a_r3_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall |-> $past(rx_level));

endmodule

// File: rtl/rto_bit_phase.sv
module rto_bit_phase #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic mid_strobe
);
    localparam int PH_W = $clog2(OVS);
    localparam logic [PH_W-1:0] MID_PH = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(OVS - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        end
    end

    assign mid_strobe = tick & ~restart & (phase == MID_PH);

    // R4: a strobe is never issued in the cycle after a restart
    a_r4_no_strobe_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !mid_strobe);

endmodule

// File: rtl/rto_window_cnt.sv
module rto_window_cnt
    import uart_rto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [WIN_W-1:0] limit,
    output logic             reached
);
    logic [WIN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step && cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt >= limit);

    // R10: a restarted window is not complete in the following cycle
    a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && limit != '0) |=> !reached);

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_rto_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick16,
    input  logic       rx_in,
    input  logic [1:0] data_bits_sel,
    input  logic       parity_en,
    input  logic       two_stop,
    input  logic       fifo_not_empty,
    input  logic       rhr_read,
    output logic       line_idle,
    output logic       rx_timeout_irq
);
    logic             rx_level;
    logic             rx_fall;
    logic             mid;
    logic [WIN_W-1:0] win_limit;
    logic             idle_reached;
    logic             to_reached;
    logic             idle_clear;
    logic             idle_step;
    logic             to_clear;
    logic             to_step;

    idle_st_t idle_st, idle_nx;
    to_st_t   to_st,   to_nx;

    rto_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_in),
        .rx_level (rx_level),
        .rx_fall  (rx_fall)
    );

    rto_bit_phase #(.OVS(OVERSAMPLE)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick16),
        .restart    (rx_fall),
        .mid_strobe (mid)
    );

    assign win_limit = window_bits(data_bits_sel, parity_en, two_stop);

    assign idle_clear = rx_fall | (mid & ~rx_level);
    assign idle_step  = mid & rx_level;

    rto_window_cnt u_idle_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clear),
        .step    (idle_step),
        .limit   (win_limit),
        .reached (idle_reached)
    );

    assign to_clear = (to_st == TO_EMPTY) | ~fifo_not_empty | rx_fall | rhr_read;
    assign to_step  = mid & (to_st == TO_TIMING);

    rto_window_cnt u_to_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (to_clear),
        .step    (to_step),
        .limit   (win_limit),
        .reached (to_reached)
    );

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_st <= IDL_WATCH;
            to_st   <= TO_EMPTY;
        end else begin
            idle_st <= idle_nx;
            to_st   <= to_nx;
        end
    end

    // idle next state
    always_comb begin
        idle_nx = idle_st;
        unique case (idle_st)
            IDL_WATCH: if (idle_reached && !rx_fall) idle_nx = IDL_QUIET;
            IDL_QUIET: if (rx_fall)                  idle_nx = IDL_WATCH;
            default:                                 idle_nx = IDL_WATCH;
        endcase
    end

    // time-out next state
    always_comb begin
        to_nx = to_st;
        unique case (to_st)
            TO_EMPTY: begin
                if (fifo_not_empty) to_nx = TO_TIMING;
            end
            TO_TIMING: begin
                if (!fifo_not_empty)                          to_nx = TO_EMPTY;
                else if (to_reached && !rx_fall && !rhr_read) to_nx = TO_EXPIRED;
            end
            TO_EXPIRED: begin
                if (!fifo_not_empty) to_nx = TO_EMPTY;
                else if (rhr_read)   to_nx = TO_TIMING;
            end
            default: to_nx = TO_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        line_idle      = (idle_st == IDL_QUIET);
        rx_timeout_irq = (to_st == TO_EXPIRED);
    end

    // R6: activity drops the idle flag
    a_r6_fall_drops_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall |=> !line_idle);

    // R8: an empty FIFO never leaves a request standing
    a_r8_empty_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_not_empty |=> !rx_timeout_irq);

    // R11: a read withdraws the request
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_read |=> !rx_timeout_irq);

    // R11: the request holds while the FIFO stays occupied and nobody reads
    a_r11_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout_irq && fifo_not_empty && !rhr_read) |=> rx_timeout_irq);

    // R9: a request only rises while the FIFO is occupied
    a_r9_rise_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_timeout_irq) |-> $past(fifo_not_empty));

endmodule

// File: tb/uart_rx_timeout_tb_top.sv
module uart_rx_timeout_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] data_bits_sel = 2'd0;
    logic       parity_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       fifo_not_empty = 1'b0;
    logic       rhr_read = 1'b0;
    logic       line_idle;
    logic       rx_timeout_irq;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    localparam int BIT_CLKS = 32;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        baud_tick16 <= ~baud_tick16;
    end

    uart_rx_timeout dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick16    (baud_tick16),
        .rx_in          (rx_in),
        .data_bits_sel  (data_bits_sel),
        .parity_en      (parity_en),
        .two_stop       (two_stop),
        .fifo_not_empty (fifo_not_empty),
        .rhr_read       (rhr_read),
        .line_idle      (line_idle),
        .rx_timeout_irq (rx_timeout_irq)
    );

    function automatic int frame_bits(input int sel, input int par, input int st2);
        return 1 + (5 + sel) + par + (1 + st2);
    endfunction

    function automatic int window_clks(input int sel, input int par, input int st2);
        return 4 * frame_bits(sel, par, st2) * BIT_CLKS;
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, exp, cyc);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic rx_pulse();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
    endtask

    task automatic read_pulse();
        rhr_read = 1'b1;
        @(negedge clk);
        rhr_read = 1'b0;
    endtask

    task automatic set_cfg(input int sel, input int par, input int st2);
        data_bits_sel = 2'(sel);
        parity_en = 1'(par);
        two_stop = 1'(st2);
    endtask

    initial begin
        repeat (4000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int t0;
        int win;
        process::self().srandom(32'h5eed1234);

        // R1: reset state
        set_cfg(3, 0, 0);
        repeat (5) @(negedge clk);
        check(line_idle, 1'b0, "R1 idle in reset");
        check(rx_timeout_irq, 1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(line_idle, 1'b0, "R1 idle after reset");
        check(rx_timeout_irq, 1'b0, "R1 irq after reset");

        // R2 R3 R4 R5: 5 data bits, no parity, one stop -> 28-bit window
        set_cfg(0, 0, 0);
        win = window_clks(0, 0, 0);
        t0 = cyc; rx_pulse();
        wait_to(t0 + win - BIT_CLKS);
        check(line_idle, 1'b0, "R5 idle not before window");
        wait_to(t0 + win + 8);
        check(line_idle, 1'b1, "R5 idle after window (R2 length)");

        // R6: activity drops idle
        t0 = cyc; rx_pulse();
        wait_to(t0 + 5);
        check(line_idle, 1'b0, "R6 activity clears idle");

        // R8 R7: FIFO empty, reads do not touch idle, no request
        set_cfg(2, 1, 1);
        win = window_clks(2, 1, 1);
        t0 = cyc; rx_pulse();
        wait_to(t0 + win / 2);
        read_pulse();
        fifo_not_empty = 1'b1; @(negedge clk); fifo_not_empty = 1'b0;
        wait_to(t0 + win + 8);
        check(line_idle, 1'b1, "R7 idle ignores read and fifo");
        wait_to(t0 + 2 * win);
        check(rx_timeout_irq, 1'b0, "R8 no request while empty");

        // R9: time-out window from FIFO fill
        t0 = cyc; fifo_not_empty = 1'b1;
        wait_to(t0 + win - BIT_CLKS - 4);
        check(rx_timeout_irq, 1'b0, "R9 no request before window");
        wait_to(t0 + win + 8);
        check(rx_timeout_irq, 1'b1, "R9 request after window");

        // R11: activity does not clear a standing request
        rx_pulse();
        wait_to(cyc + 6);
        check(rx_timeout_irq, 1'b1, "R11 activity keeps request");

        // R11 R10: read clears, later activity restarts the count
        read_pulse();
        @(negedge clk);
        check(rx_timeout_irq, 1'b0, "R11 read clears request");
        wait_to(cyc + win / 2);
        t0 = cyc; rx_pulse();
        wait_to(t0 + win - BIT_CLKS);
        check(rx_timeout_irq, 1'b0, "R10 activity restarted count");
        wait_to(t0 + win + 8);
        check(rx_timeout_irq, 1'b1, "R10 request after restarted window");

        // R11: FIFO empties -> request falls
        fifo_not_empty = 1'b0;
        @(negedge clk); @(negedge clk);
        check(rx_timeout_irq, 1'b0, "R11 empty clears request");

        // random frame shapes with optional mid-window read
        for (int it = 0; it < 12; it++) begin
            int sel, par, st2, off;
            sel = $urandom_range(0, 3);
            par = $urandom_range(0, 1);
            st2 = $urandom_range(0, 1);
            set_cfg(sel, par, st2);
            win = window_clks(sel, par, st2);
            t0 = cyc; rx_pulse();
            wait_to(t0 + win - BIT_CLKS);
            check(line_idle, 1'b0, "R5 random idle early");
            wait_to(t0 + win + 8);
            check(line_idle, 1'b1, "R5 random idle late (R2)");
            t0 = cyc; fifo_not_empty = 1'b1;
            if ($urandom_range(0, 1) == 1) begin
                off = $urandom_range(4, frame_bits(sel, par, st2) * 3) * BIT_CLKS;
                wait_to(t0 + off);
                t0 = cyc; read_pulse();
                wait_to(t0 + win - BIT_CLKS - 4);
                check(rx_timeout_irq, 1'b0, "R10 random read restarts");
            end else begin
                wait_to(t0 + win - BIT_CLKS - 4);
                check(rx_timeout_irq, 1'b0, "R9 random early");
            end
            wait_to(t0 + win + 8);
            check(rx_timeout_irq, 1'b1, "R9 random request");
            fifo_not_empty = 1'b0;
            @(negedge clk); @(negedge clk);
            check(rx_timeout_irq, 1'b0, "R8 random empty");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule